// File: doc/BRIEF.md
# Variable-Length Bit Packing Buffer

This block packs a stream of variable-length bit fields into one wide working register. Each input beat is up to 64 bits wide and comes with a count of how many of its low-order bits are meaningful. Those bits are written at the current fill position, and the position then advances by the count. Successive beats of one message therefore form a contiguous bit string. Bit 0 of the register is the first bit filled, and a beat may begin at any bit offset.

A message can be anywhere from 0 to 16000 bits long, so one message may fill the 1024-bit register several times. Intake stops when the register becomes full, or when the beat marked last has been written. The register is then presented to a downstream processing stage together with its fill count. When that stage pulses its done input, the register is cleared and intake resumes. A beat that crosses the 1024-bit boundary contributes only the bits that fit. Its remaining high bits are held back and written at offset 0 when intake resumes.

The insertion path has a fixed structure: a length mask, followed by a left barrel shift by the fill position, followed by an OR into the register. No slice has a range that depends on run-time values.

Top module: `bitpack_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `in_ready` and `out_valid` are 0, `out_count` is 0 and `out_buf` is all zeros. `in_ready` rises after the first clock edge following release.
- R2: For an accepted beat, bit i of `in_data` (i < `in_len`) lands at `out_buf` bit `out_count + i`. Bits already in the register are unchanged.
- R3: Bits of `in_data` at index `in_len` or above have no effect on `out_buf`.
- R4: An accepted beat that does not reach the 1024 boundary advances `out_count` by exactly `in_len`. A beat with `in_len` = 0 and `in_last` = 0 changes nothing.
- R5: When the fill count reaches exactly 1024, `out_valid` goes to 1 on the next cycle, with `out_msg_end` = 0 unless the beat was also last.
- R6: After a beat with `in_last` = 1 that does not overflow, `out_valid` = 1 and `out_msg_end` = 1, with `out_count` equal to the total bits packed.
- R7: A zero-length last beat still hands off the partially filled register. An empty message hands off an all-zero register with `out_count` = 0.
- R8: A beat that crosses the boundary fills the register to 1024 and hands it off. After the resume, its remaining high bits are placed starting at bit 0, with `out_count` equal to their number.
- R9: While `out_valid` is 1, `in_ready` is 0, and `out_buf` and `out_count` hold steady until `proc_done` is pulsed.
- R10: One cycle after `proc_done` is pulsed during a handoff, `out_valid` is 0, `in_ready` is 1 and the register is cleared. This does not apply when R11 applies.
- R11: If the crossing beat was last, the resume places the remainder and hands the register off again at once, with `out_msg_end` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_data | input | 64 | Beat payload, valid bits in the low positions |
| in_len | input | 7 | Number of valid bits, 0 to 64 |
| in_last | input | 1 | Beat ends the message |
| out_valid | output | 1 | Register handed to the processing stage |
| out_msg_end | output | 1 | This handoff closes the message |
| out_count | output | 11 | Fill count, 0 to 1024 |
| out_buf | output | 1024 | Working register contents |
| proc_done | input | 1 | Processing finished, resume intake |

## Verification
Every result is due one clock edge after its stimulus, because each path ends in a single register stage. An accepted beat shows up in `out_buf`, `out_count` and `out_valid` one edge later. A `proc_done` pulse clears the register, or loads the remainder, on the same next edge. The bench changes inputs on the falling edge and samples one falling edge later, so exactly one rising edge falls between a stimulus and its check. During each handoff, the bench waits one extra idle cycle to confirm that the register holds.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_TAKE  = 2'd1,
        ST_HOLD  = 2'd2
    } bp_state_e;
endpackage

// File: rtl/bitpack_mask.sv
// Zeroes every payload bit at or above the valid length.
module bitpack_mask #(
    parameter int BEAT_W = 64,
    parameter int LEN_W  = 7
) (
    input  logic [BEAT_W-1:0] raw_word,
    input  logic [LEN_W-1:0]  valid_len,
    output logic [BEAT_W-1:0] clean_word
);
    for (genvar g = 0; g < BEAT_W; g++) begin : g_bit
        assign clean_word[g] = raw_word[g] & (valid_len > LEN_W'(g));
    end
endmodule

// File: rtl/bitpack_merge.sv
// Positions a masked beat at the fill offset and splits off the overflow part.
module bitpack_merge #(
    parameter int BUF_W  = 1024,
    parameter int BEAT_W = 64,
    parameter int LEN_W  = 7,
    parameter int POS_W  = 11
) (
    input  logic [BEAT_W-1:0] clean_word,
    input  logic [LEN_W-1:0]  valid_len,
    input  logic [POS_W-1:0]  fill_pos,
    output logic [BUF_W-1:0]  place_vec,
    output logic              overflow,
    output logic [BEAT_W-1:0] spill_word,
    output logic [LEN_W-1:0]  spill_len,
    output logic [POS_W-1:0]  next_pos
);
    localparam logic [POS_W-1:0] FULL = POS_W'(BUF_W);

    logic [POS_W-1:0] room;
    logic [POS_W-1:0] len_ext;

    always_comb begin
        room      = FULL - fill_pos;
        len_ext   = POS_W'(valid_len);
        overflow  = len_ext > room;
        place_vec = BUF_W'(clean_word) << fill_pos;
        if (overflow) begin
            spill_word = clean_word >> room;
            spill_len  = LEN_W'(len_ext - room);
            next_pos   = FULL;
        end else begin
            spill_word = '0;
            spill_len  = '0;
            next_pos   = fill_pos + len_ext;
        end
    end
endmodule

// File: rtl/bitpack_buffer.sv
module bitpack_buffer
    import bitpack_pkg::*;
#(
    parameter int BUF_W  = 1024,
    parameter int BEAT_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [BEAT_W-1:0]            in_data,
    input  logic [$clog2(BEAT_W+1)-1:0]  in_len,
    input  logic                         in_last,
    output logic                         out_valid,
    output logic                         out_msg_end,
    output logic [$clog2(BUF_W+1)-1:0]   out_count,
    output logic [BUF_W-1:0]             out_buf,
    input  logic                         proc_done
);
    localparam int LEN_W = $clog2(BEAT_W + 1);
    localparam int POS_W = $clog2(BUF_W + 1);
    localparam logic [POS_W-1:0] FULL = POS_W'(BUF_W);

    typedef struct packed {
        bp_state_e         st;
        logic [BUF_W-1:0]  fill_vec;
        logic [POS_W-1:0]  pos;
        logic [BEAT_W-1:0] spill_word;
        logic [LEN_W-1:0]  spill_len;
        logic              spill_last;
        logic              msg_end;
    } regs_t;

    regs_t r_d, r_q;

    logic [BEAT_W-1:0] clean_word;
    logic [BUF_W-1:0]  place_vec;
    logic              overflow;
    logic [BEAT_W-1:0] spill_word;
    logic [LEN_W-1:0]  spill_len;
    logic [POS_W-1:0]  next_pos;
    logic              accept;

    bitpack_mask #(.BEAT_W(BEAT_W), .LEN_W(LEN_W)) i_mask (
        .raw_word   (in_data),
        .valid_len  (in_len),
        .clean_word (clean_word)
    );

    bitpack_merge #(.BUF_W(BUF_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W), .POS_W(POS_W)) i_merge (
        .clean_word (clean_word),
        .valid_len  (in_len),
        .fill_pos   (r_q.pos),
        .place_vec  (place_vec),
        .overflow   (overflow),
        .spill_word (spill_word),
        .spill_len  (spill_len),
        .next_pos   (next_pos)
    );

    assign in_ready    = (r_q.st == ST_TAKE);
    assign accept      = in_valid && in_ready;
    assign out_valid   = (r_q.st == ST_HOLD);
    assign out_msg_end = r_q.msg_end;
    assign out_count   = r_q.pos;
    assign out_buf     = r_q.fill_vec;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RESET: begin
                r_d.st         = ST_TAKE;
                r_d.fill_vec   = '0;
                r_d.pos        = '0;
                r_d.spill_word = '0;
                r_d.spill_len  = '0;
                r_d.spill_last = 1'b0;
                r_d.msg_end    = 1'b0;
            end
            ST_TAKE: begin
                if (accept) begin
                    r_d.fill_vec = r_q.fill_vec | place_vec;
                    r_d.pos      = next_pos;
                    if (overflow) begin
                        r_d.spill_word = spill_word;
                        r_d.spill_len  = spill_len;
                        r_d.spill_last = in_last;
                        r_d.msg_end    = 1'b0;
                        r_d.st         = ST_HOLD;
                    end else if (next_pos == FULL || in_last) begin
                        r_d.msg_end = in_last;
                        r_d.st      = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (proc_done) begin
                    r_d.fill_vec   = BUF_W'(r_q.spill_word);
                    r_d.pos        = POS_W'(r_q.spill_len);
                    r_d.spill_word = '0;
                    r_d.spill_len  = '0;
                    r_d.spill_last = 1'b0;
                    r_d.msg_end    = r_q.spill_last;
                    r_d.st         = r_q.spill_last ? ST_HOLD : ST_TAKE;
                end
            end
            default: r_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RESET, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic [POS_W:0] sum_w;
    assign sum_w = {1'b0, out_count} + (POS_W+1)'(in_len);

    // R9
    ready_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !proc_done) |=> (out_valid && $stable(out_buf) && $stable(out_count)));

    // R4
    advance_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_last && sum_w < (POS_W+1)'(BUF_W))
        |=> (out_count == POS_W'($past(sum_w))));

    // R5
    handoff_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_count == FULL || out_msg_end));

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= FULL);

    // R10
    resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && proc_done && !r_q.spill_last) |=> (!out_valid && in_ready));
endmodule

// File: tb/test_bitpack_buffer.sv
`timescale 1ns/1ps
module test_bitpack_buffer;
    localparam int BUF_W = 1024;
    localparam int BEAT_W = 64;
    localparam int TBL_N = 9;

    // row: {data[63:0], len[6:0], last}
    localparam logic [71:0] TBL [TBL_N] = '{
        {64'hFFFF_FFFF_FFFF_FFE5, 7'd5,  1'b0},
        {64'h0123_4567_89AB_CDEF, 7'd64, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'd0,  1'b0},
        {64'hDEAD_BEEF_CAFE_F00D, 7'd13, 1'b0},
        {64'hA5A5_A5A5_5A5A_5A5A, 7'd64, 1'b0},
        {64'h0F0F_0F0F_F0F0_F0F0, 7'd37, 1'b1},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'd0,  1'b1},
        {64'h1357_9BDF_2468_ACE1, 7'd1,  1'b0},
        {64'hFFFF_0000_FFFF_0000, 7'd0,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [63:0] in_data = '0;
    logic [6:0] in_len = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_msg_end;
    logic [10:0] out_count;
    logic [BUF_W-1:0] out_buf;
    logic proc_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [BUF_W-1:0] m_buf = '0;
    int m_cnt = 0;
    logic [63:0] m_car = '0;
    int m_clen = 0;
    bit m_clast = 1'b0;

    always #4 clk = ~clk;

    bitpack_buffer #(.BUF_W(BUF_W), .BEAT_W(BEAT_W)) i_bitpack_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_msg_end(out_msg_end), .out_count(out_count),
        .out_buf(out_buf), .proc_done(proc_done)
    );

    task automatic chk(bit ok, string tag, logic [BUF_W-1:0] act, logic [BUF_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int k);
        return {32'(k * 32'h9E37_79B1), 32'(k) ^ 32'h5A3C_0FF1};
    endfunction

    task automatic resume();
        bit again;
        do begin
            proc_done = 1'b1;
            @(negedge clk);
            proc_done = 1'b0;
            m_buf = '0;
            for (int i = 0; i < m_clen; i++) m_buf[i] = m_car[i];
            m_cnt = m_clen;
            again = m_clast;
            chk(out_count == 11'(m_cnt), m_clen > 0 ? "R8 count after resume" : "R10 count after resume",
                BUF_W'(out_count), BUF_W'(m_cnt));
            chk(out_buf == m_buf, m_clen > 0 ? "R8 remainder at bit 0" : "R10 register cleared",
                out_buf, m_buf);
            chk(out_valid == again, "R10 R11 handoff state after resume", BUF_W'(out_valid), BUF_W'(again));
            chk(in_ready == !again, "R10 ready after resume", BUF_W'(in_ready), BUF_W'(!again));
            if (again) chk(out_msg_end == 1'b1, "R11 message end on remainder", BUF_W'(out_msg_end), 1);
            m_car = '0;
            m_clen = 0;
            m_clast = 1'b0;
        end while (again);
    endtask

    task automatic send(logic [63:0] d, int len, bit last);
        bit hold;
        bit exp_end;
        chk(in_ready == 1'b1, "R9 ready before beat", BUF_W'(in_ready), 1);
        in_data = d;
        in_len = 7'(len);
        in_last = last;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (m_cnt < BUF_W) begin
                m_buf[m_cnt] = d[i];
                m_cnt++;
            end else begin
                m_car[m_clen] = d[i];
                m_clen++;
            end
        end
        m_clast = last && (m_clen > 0);
        exp_end = last && (m_clen == 0);
        hold = (m_cnt == BUF_W) || last;
        chk(out_count == 11'(m_cnt), "R4 fill count", BUF_W'(out_count), BUF_W'(m_cnt));
        chk(out_buf == m_buf, "R2 R3 packed contents", out_buf, m_buf);
        chk(out_valid == hold, m_cnt == BUF_W ? "R5 handoff at full" : "R6 handoff state",
            BUF_W'(out_valid), BUF_W'(hold));
        if (hold) begin
            chk(out_msg_end == exp_end, last ? "R6 message end flag" : "R5 message end flag",
                BUF_W'(out_msg_end), BUF_W'(exp_end));
            if (last && m_cnt < BUF_W && len == 0)
                chk(out_count == 11'(m_cnt), "R7 partial handoff count", BUF_W'(out_count), BUF_W'(m_cnt));
            @(negedge clk);
            chk(out_valid && !in_ready, "R9 ready low during hold", BUF_W'(in_ready), 0);
            chk(out_buf == m_buf, "R9 register stable in hold", out_buf, m_buf);
            resume();
        end
    endtask

    task automatic fill_full_beats(int n, int base);
        for (int k = 0; k < n; k++) send(pat(base + k), 64, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R1 handshake in reset", BUF_W'({in_ready, out_valid}), 0);
        chk(out_count == '0, "R1 count in reset", BUF_W'(out_count), 0);
        chk(out_buf == '0, "R1 register in reset", out_buf, '0);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R1 ready before first edge", BUF_W'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after first edge", BUF_W'(in_ready), 1);
        chk(out_count == '0 && out_buf == '0, "R1 clean after reset", BUF_W'(out_count), 0);

        // table walk: R2 R3 R4 R6 R7
        for (int r = 0; r < TBL_N; r++) send(TBL[r][71:8], int'(TBL[r][7:1]), TBL[r][0]);

        // R8: crossing beat, remainder 16 bits
        fill_full_beats(15, 100);
        send(pat(200), 50, 1'b0);
        send(pat(201), 30, 1'b0);
        // R5: exact fill without remainder
        fill_full_beats(15, 300);
        send(pat(400), 48, 1'b0);
        // R11: crossing beat that is last
        fill_full_beats(15, 500);
        send(pat(600), 40, 1'b0);
        send(pat(601), 40, 1'b1);
        // R7: empty message after all of that
        send(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule